// File: doc/BRIEF.md
# Minimal Adaptive Mesh Route Selector

This block is the route-computation stage of a switch in a two-dimensional mesh on-chip network. The switch's own column and row are fixed by parameters. Each of the four neighbouring links (west, north, east, south) reports its congestion level on a dedicated input together with an update strobe. The block keeps the last reported level of each link in a register. A flit header carries only a destination node number. For each valid header, the block picks one output port. The candidates are only the directions that shorten the path to the destination. Among them it takes the one whose link is least loaded.

A node number is split into a column, `id mod COLS`, and a row, `id div COLS`. North points towards smaller row numbers. When the destination differs in only one dimension, the block takes the single productive direction. When it differs in both, the block compares the two stored link levels. The decision is registered and is announced by a one-cycle valid pulse. The mesh size and the node's position are parameters. The default is a 5x5 mesh, and 3x3 and 10x10 meshes are built by changing parameters.

Top module: `mesh_route_select`

## Requirements
- R1: The output port codes are 0 = local, 1 = west, 2 = north, 3 = east and 4 = south. The values 5 to 7 never appear on `route_port` while `route_valid` is high.
- R2: A destination number maps to column `id mod COLS` and row `id div COLS`. A destination equal to the node's own position yields port 0.
- R3: When exactly one dimension differs, the block chooses that dimension's productive direction (east when the destination column is larger, west when smaller, south when the destination row is larger, north when smaller). It makes this choice whatever the stored congestion levels are.
- R4: When both dimensions differ, the block chooses the productive direction whose link has the lower level. On equal levels it chooses the column direction (east or west).
- R5: Congestion levels are coded 2'b00 low, 2'b01 medium and 2'b10 high. The code 2'b11 compares exactly like high.
- R6: A link's level is loaded only in a cycle where its update strobe is high. It is kept for all later headers until the next strobe. A header presented in the same cycle as an update is routed with the previous level. Level data presented without a strobe has no effect.
- R7: The chosen direction is never non-productive. A destination with a larger row is never sent north, one with a smaller row never south, one with a larger column never west, and one with a smaller column never east.
- R8: `route_valid` is high exactly in the cycle after each cycle with `header_valid` high and low otherwise. Back-to-back headers give back-to-back decisions.
- R9: Reset clears `route_valid` and `route_port` to 0 and sets all four stored levels to low.
- R10: The mesh columns, rows and the node's own column and row are parameters. The block routes correctly for 3x3, 5x5 and 10x10 meshes and for corner positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| west_upd | input | 1 | Strobe loading the west link level |
| west_lvl | input | 2 | West link congestion level |
| north_upd | input | 1 | Strobe loading the north link level |
| north_lvl | input | 2 | North link congestion level |
| east_upd | input | 1 | Strobe loading the east link level |
| east_lvl | input | 2 | East link congestion level |
| south_upd | input | 1 | Strobe loading the south link level |
| south_lvl | input | 2 | South link congestion level |
| header_valid | input | 1 | A flit header is present |
| header_dest | input | $clog2(COLS*ROWS) | Destination node number |
| route_valid | output | 1 | One-cycle pulse: decision available |
| route_port | output | 3 | Chosen output port code |

## Verification
A header's decision is due in the cycle after the header is sampled. The bench drives inputs on the falling edge and compares `route_valid` and `route_port` on the next falling edge. A level update becomes visible to headers one edge after its strobe, so every congestion setting is loaded a full cycle before the first header that relies on it. The only exception is the same-cycle case of R6, which is checked on purpose. The sweep covers every destination for all 256 level combinations on three mesh configurations at once, with headers back to back. An idle cycle after each burst checks that no extra pulse appears.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

   localparam int LVL_W  = 2;
   localparam int PORT_W = 3;
   localparam int NLINK  = 4;

   // link slot indices used for the level register array
   localparam int LNK_WEST  = 0;
   localparam int LNK_NORTH = 1;
   localparam int LNK_EAST  = 2;
   localparam int LNK_SOUTH = 3;

   typedef enum logic [PORT_W-1:0] {
      PORT_LOCAL = 3'd0,
      PORT_WEST  = 3'd1,
      PORT_NORTH = 3'd2,
      PORT_EAST  = 3'd3,
      PORT_SOUTH = 3'd4
   } port_e;

   localparam logic [LVL_W-1:0] LVL_LOW  = 2'b00;
   localparam logic [LVL_W-1:0] LVL_HIGH = 2'b10;

   // the unused code saturates onto the high level
   function automatic logic [LVL_W-1:0] lvl_sat(input logic [LVL_W-1:0] raw);
      return (raw == 2'b11) ? LVL_HIGH : raw;
   endfunction

endpackage

// File: rtl/mrs_link_state.sv
module mrs_link_state #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd,
   input  logic [W-1:0] lvl_in,
   output logic [W-1:0] lvl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= '0;
      else if (upd) lvl_q <= lvl_in;
   end

endmodule

// File: rtl/mrs_dest_decode.sv
module mrs_dest_decode #(
   parameter int COLS = 5,
   parameter int ROWS = 5,
   parameter int MY_X = 2,
   parameter int MY_Y = 2,
   parameter int ID_W = 5
) (
   input  logic [ID_W-1:0] dest,
   output logic            go_east,
   output logic            go_west,
   output logic            go_north,
   output logic            go_south
);

   localparam int CW = 32;

   logic [CW-1:0] dest_w;
   logic [CW-1:0] col;
   logic [CW-1:0] row;

   always_comb begin
      dest_w   = CW'(dest);
      col      = dest_w % CW'(COLS);
      row      = dest_w / CW'(COLS);
      go_east  = col > CW'(MY_X);
      go_west  = col < CW'(MY_X);
      go_south = row > CW'(MY_Y);
      go_north = row < CW'(MY_Y);
   end

endmodule

// File: rtl/mrs_dir_pick.sv
module mrs_dir_pick
   import mrs_pkg::*;
#(
   parameter bit TIE_TO_X = 1'b1
) (
   input  logic             go_east,
   input  logic             go_west,
   input  logic             go_north,
   input  logic             go_south,
   input  logic [LVL_W-1:0] lvl [NLINK],
   output port_e            pick
);

   port_e            x_port;
   port_e            y_port;
   logic [LVL_W-1:0] x_lvl;
   logic [LVL_W-1:0] y_lvl;
   logic             x_wins;

   always_comb begin
      x_port = go_east ? PORT_EAST  : (go_west  ? PORT_WEST  : PORT_LOCAL);
      y_port = go_south ? PORT_SOUTH : (go_north ? PORT_NORTH : PORT_LOCAL);
      x_lvl  = lvl_sat(go_east  ? lvl[LNK_EAST]  : lvl[LNK_WEST]);
      y_lvl  = lvl_sat(go_south ? lvl[LNK_SOUTH] : lvl[LNK_NORTH]);
   end

   generate
      if (TIE_TO_X) begin : g_tie_x
         assign x_wins = (x_lvl <= y_lvl);
      end else begin : g_tie_y
         assign x_wins = (x_lvl < y_lvl);
      end
   endgenerate

   always_comb begin
      if (x_port == PORT_LOCAL)      pick = y_port;
      else if (y_port == PORT_LOCAL) pick = x_port;
      else if (x_wins)               pick = x_port;
      else                           pick = y_port;
   end

endmodule

// File: rtl/mesh_route_select.sv
module mesh_route_select
   import mrs_pkg::*;
#(
   parameter int COLS     = 5,
   parameter int ROWS     = 5,
   parameter int MY_X     = 2,
   parameter int MY_Y     = 2,
   parameter bit TIE_TO_X = 1'b1,
   localparam int NODES   = COLS * ROWS,
   localparam int ID_W    = (NODES > 1) ? $clog2(NODES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              west_upd,
   input  logic [1:0]        west_lvl,
   input  logic              north_upd,
   input  logic [1:0]        north_lvl,
   input  logic              east_upd,
   input  logic [1:0]        east_lvl,
   input  logic              south_upd,
   input  logic [1:0]        south_lvl,
   input  logic              header_valid,
   input  logic [ID_W-1:0]   header_dest,
   output logic              route_valid,
   output logic [2:0]        route_port
);

   generate
      if (COLS < 2 || ROWS < 2) begin : g_bad_dim
         $error("mesh needs at least two columns and two rows");
      end
      if (MY_X < 0 || MY_X >= COLS || MY_Y < 0 || MY_Y >= ROWS) begin : g_bad_pos
         $error("own position lies outside the mesh");
      end
      if (LVL_W != 2 || PORT_W != 3) begin : g_bad_pkg
         $error("package widths do not match port widths");
      end
   endgenerate

   logic             upd_v [NLINK];
   logic [LVL_W-1:0] lvl_in [NLINK];
   logic [LVL_W-1:0] lvl_q [NLINK];

   always_comb begin
      upd_v[LNK_WEST]   = west_upd;
      upd_v[LNK_NORTH]  = north_upd;
      upd_v[LNK_EAST]   = east_upd;
      upd_v[LNK_SOUTH]  = south_upd;
      lvl_in[LNK_WEST]  = west_lvl;
      lvl_in[LNK_NORTH] = north_lvl;
      lvl_in[LNK_EAST]  = east_lvl;
      lvl_in[LNK_SOUTH] = south_lvl;
   end

   generate
      for (genvar li = 0; li < NLINK; li++) begin : g_link
         mrs_link_state #(.W(LVL_W)) u_state (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd_v[li]),
            .lvl_in (lvl_in[li]),
            .lvl_q  (lvl_q[li])
         );
      end
   endgenerate

   logic  go_e, go_w, go_n, go_s;
   port_e pick;

   mrs_dest_decode #(
      .COLS (COLS),
      .ROWS (ROWS),
      .MY_X (MY_X),
      .MY_Y (MY_Y),
      .ID_W (ID_W)
   ) u_decode (
      .dest     (header_dest),
      .go_east  (go_e),
      .go_west  (go_w),
      .go_north (go_n),
      .go_south (go_s)
   );

   mrs_dir_pick #(.TIE_TO_X(TIE_TO_X)) u_pick (
      .go_east  (go_e),
      .go_west  (go_w),
      .go_north (go_n),
      .go_south (go_s),
      .lvl      (lvl_q),
      .pick     (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_valid <= 1'b0;
         route_port  <= '0;
      end else begin
         route_valid <= header_valid;
         if (header_valid) route_port <= pick;
      end
   end

endmodule

// File: rtl/mrs_route_checker.sv
module mrs_route_checker #(
   parameter int COLS = 5,
   parameter int ROWS = 5,
   parameter int MY_X = 2,
   parameter int MY_Y = 2,
   parameter int ID_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            header_valid,
   input logic [ID_W-1:0] header_dest,
   input logic            route_valid,
   input logic [2:0]      route_port
);

   localparam int MY_ID = MY_Y * COLS + MY_X;

   assert_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      header_valid |=> route_valid);

   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !header_valid |=> !route_valid);

   assert_port_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> (route_port <= 3'd4));

   assert_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (header_valid && int'(header_dest) == MY_ID) |=> (route_port == 3'd0));

   assert_not_north_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (header_valid && (int'(header_dest) / COLS) > MY_Y) |=> (route_port != 3'd2));

   assert_not_south_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (header_valid && (int'(header_dest) / COLS) < MY_Y) |=> (route_port != 3'd4));

   assert_not_west_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (header_valid && (int'(header_dest) % COLS) > MY_X) |=> (route_port != 3'd1));

   assert_not_east_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (header_valid && (int'(header_dest) % COLS) < MY_X) |=> (route_port != 3'd3));

   assert_reset_quiet_R9: assert property (@(posedge clk)
      !rst_n |-> !route_valid);

endmodule

bind mesh_route_select mrs_route_checker #(
   .COLS (COLS),
   .ROWS (ROWS),
   .MY_X (MY_X),
   .MY_Y (MY_Y),
   .ID_W (ID_W)
) u_route_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .header_valid (header_valid),
   .header_dest  (header_dest),
   .route_valid  (route_valid),
   .route_port   (route_port)
);

// File: tb/mesh_route_select_bench.sv
`timescale 1ns/1ps
module mesh_route_select_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       w_u = 0, n_u = 0, e_u = 0, s_u = 0;
   logic [1:0] w_l = 0, n_l = 0, e_l = 0, s_l = 0;

   logic       hv_a = 0, hv_b = 0, hv_c = 0;
   logic [4:0] hd_a = 0;
   logic [3:0] hd_b = 0;
   logic [6:0] hd_c = 0;
   logic       rv_a, rv_b, rv_c;
   logic [2:0] rp_a, rp_b, rp_c;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // default 5x5 mesh, centre node
   mesh_route_select u_mesh_route_select (
      .clk(clk), .rst_n(rst_n),
      .west_upd(w_u), .west_lvl(w_l), .north_upd(n_u), .north_lvl(n_l),
      .east_upd(e_u), .east_lvl(e_l), .south_upd(s_u), .south_lvl(s_l),
      .header_valid(hv_a), .header_dest(hd_a),
      .route_valid(rv_a), .route_port(rp_a));

   // 3x3 mesh, bottom-left corner
   mesh_route_select #(.COLS(3), .ROWS(3), .MY_X(0), .MY_Y(2)) u_small (
      .clk(clk), .rst_n(rst_n),
      .west_upd(w_u), .west_lvl(w_l), .north_upd(n_u), .north_lvl(n_l),
      .east_upd(e_u), .east_lvl(e_l), .south_upd(s_u), .south_lvl(s_l),
      .header_valid(hv_b), .header_dest(hd_b),
      .route_valid(rv_b), .route_port(rp_b));

   // 10x10 mesh, off-centre node
   mesh_route_select #(.COLS(10), .ROWS(10), .MY_X(7), .MY_Y(3)) u_large (
      .clk(clk), .rst_n(rst_n),
      .west_upd(w_u), .west_lvl(w_l), .north_upd(n_u), .north_lvl(n_l),
      .east_upd(e_u), .east_lvl(e_l), .south_upd(s_u), .south_lvl(s_l),
      .header_valid(hv_c), .header_dest(hd_c),
      .route_valid(rv_c), .route_port(rp_c));

   task automatic check(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic int sat(int l);
      return (l == 3) ? 2 : l;
   endfunction

   // expected port from the requirement text
   function automatic int model(int d, int cols, int mx, int my,
                                int cw, int cn, int ce, int cs);
      int x, y, xd, yd, lx, ly;
      x  = d % cols;
      y  = d / cols;
      xd = (x > mx) ? 3 : ((x < mx) ? 1 : 0);
      yd = (y > my) ? 4 : ((y < my) ? 2 : 0);
      if (yd == 0) return xd;
      if (xd == 0) return yd;
      lx = (xd == 3) ? ce : cw;
      ly = (yd == 4) ? cs : cn;
      return (sat(lx) <= sat(ly)) ? xd : yd;
   endfunction

   function automatic string kind(int d, int cols, int mx, int my, int c);
      int x, y;
      x = d % cols;
      y = d / cols;
      if (x == mx && y == my) return "R2";
      if (x == mx || y == my) return "R3";
      if (c[1:0] == 3 || c[3:2] == 3 || c[5:4] == 3 || c[7:6] == 3) return "R5";
      return "R4";
   endfunction

   task automatic set_levels(int cw, int cn, int ce, int cs);
      @(negedge clk);
      w_u = 1; n_u = 1; e_u = 1; s_u = 1;
      w_l = 2'(cw); n_l = 2'(cn); e_l = 2'(ce); s_l = 2'(cs);
      @(negedge clk);
      w_u = 0; n_u = 0; e_u = 0; s_u = 0;
   endtask

   // one header on the default instance, result checked one cycle later
   task automatic route_a(int d, int exp, string tag);
      @(negedge clk);
      hv_a = 1; hd_a = 5'(d);
      @(negedge clk);
      hv_a = 0;
      check({tag, " valid"}, int'(rv_a), 1);
      check({tag, " port"}, int'(rp_a), exp);
   endtask

   initial begin
      #(5ns * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit pa, pb, pc;
      int da, db, dc, cc;
      pa = 0; pb = 0; pc = 0; da = 0; db = 0; dc = 0; cc = 0;

      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 valid in reset", int'(rv_a), 0);
      check("R9 port in reset", int'(rp_a), 0);
      rst_n = 1;
      @(negedge clk);
      check("R9 valid after reset", int'(rv_a), 0);
      // R9: all levels low, so a diagonal destination ties and goes east
      route_a(18, 3, "R9 reset levels tie");
      // R4: tie preference for the column direction on the west side
      route_a(6, 1, "R4 tie west");

      // R6: same-cycle update uses the previous level
      set_levels(0, 0, 0, 1);
      @(negedge clk);
      hv_a = 1; hd_a = 5'd18; e_u = 1; e_l = 2'd2;
      @(negedge clk);
      hv_a = 0; e_u = 0; e_l = 2'd0;
      check("R6 same-cycle old level", int'(rp_a), 3);
      route_a(18, 4, "R6 new level in use");
      repeat (4) @(negedge clk);
      route_a(18, 4, "R6 level held");
      // level data without a strobe is ignored
      @(negedge clk);
      e_l = 2'd0; e_u = 0;
      route_a(18, 4, "R6 no strobe no effect");
      // R5: code 3 equals high, tie goes to the column direction
      set_levels(0, 0, 3, 2);
      route_a(18, 3, "R5 code3 equals high");
      // R7/R3: due south with a jammed south link still goes south
      set_levels(0, 0, 0, 2);
      route_a(22, 4, "R3 single dim ignores level");
      // R8: no pulse while idle
      @(negedge clk);
      check("R8 idle no pulse", int'(rv_a), 0);

      // exhaustive sweep: all level combinations, all destinations, three meshes
      for (int c = 0; c < 256; c++) begin
         set_levels(c & 3, (c >> 2) & 3, (c >> 4) & 3, (c >> 6) & 3);
         for (int d = 0; d <= 100; d++) begin
            @(negedge clk);
            if (pa) begin
               check({kind(da, 5, 2, 2, cc), " 5x5 port"}, int'(rp_a),
                     model(da, 5, 2, 2, c & 3, (c >> 2) & 3, (c >> 4) & 3, (c >> 6) & 3));
               check("R1 port code range", int'(rp_a <= 3'd4), 1);
            end
            check("R8 pulse 5x5", int'(rv_a), int'(pa));
            if (pb) check("R10 3x3 port", int'(rp_b),
                          model(db, 3, 0, 2, c & 3, (c >> 2) & 3, (c >> 4) & 3, (c >> 6) & 3));
            check("R8 pulse 3x3", int'(rv_b), int'(pb));
            if (pc) begin
               check("R10 10x10 port", int'(rp_c),
                     model(dc, 10, 7, 3, c & 3, (c >> 2) & 3, (c >> 4) & 3, (c >> 6) & 3));
               if ((dc / 10) > 3)
                  check("R7 south dest not north", int'(rp_c == 3'd2), 0);
            end
            check("R8 pulse 10x10", int'(rv_c), int'(pc));
            cc = c;
            pa = (d < 25); pb = (d < 9); pc = (d < 100);
            da = d; db = d; dc = d;
            hv_a = pa; hd_a = 5'(d);
            hv_b = pb; hd_b = 4'(d);
            hv_c = pc; hd_c = 7'(d);
         end
         hv_a = 0; hv_b = 0; hv_c = 0;
         pa = 0; pb = 0; pc = 0;
      end

      @(negedge clk);
      check("R8 final idle", int'(rv_a | rv_b | rv_c), 0);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule